// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Atomic Register Aliases

This block generates several independent pulse-width modulated outputs, each programmed over a simple 32-bit register bus with a word address, write data, a write strobe and combinational read data. One control register carries an enable bit per channel. Each channel owns two registers. The window register gives the counts at which the active phase starts and ends. The cycle register holds the cycle length, the drive code for the active phase, the drive code for the inactive phase, and a power-of-two clock prescaler.

Every register answers at four addresses: the base address and three aliases that OR, AND-NOT or XOR the write data into the stored value. Software can therefore change single bits, such as one channel's enable, without a read-modify-write sequence. Each channel counter runs from zero up to the programmed cycle value and then wraps. The window and cycle settings are copied into the running channel only at that wrap, or at any time while the channel is disabled. A cycle that has started always completes with the settings it began with.

Each channel drives a level and an output-enable. A drive code can place the pin in high impedance, drive it low or drive it high, separately for the active and the inactive phase.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero, every channel is disabled, and every `pwm_oe` and `pwm_level` bit is 0.
- R2: Byte offset bits 3:2 select the access kind: 0 writes the value, 1 ORs the write data in, 2 clears the bits set in the write data, 3 inverts the bits set in the write data. A read at any of the four offsets returns the stored base value.
- R3: The control register is at byte address 0x00, and bit n enables channel n. Channel n's window register is at 0x10+0x20·n and its cycle register is at 0x20+0x20·n. Unused bits read zero: control bits from NCH up and cycle bits 31:23. Addresses above the last channel read zero, and writes to them change nothing.
- R4: An enabled channel counter advances on each prescaler tick from 0 up to the cycle value in cycle bits 15:0 and then returns to 0, so one output cycle lasts (cycle value + 1) ticks.
- R5: A channel is in its active phase while start ≤ count < end, where start is window bits 15:0 and end is window bits 31:16. It is in its inactive phase otherwise.
- R6: Cycle bits 17:16 give the drive code for the active phase and bits 19:18 the code for the inactive phase. Codes 0 and 1 give oe=0 and level=0, code 2 gives oe=1 and level=0, and code 3 gives oe=1 and level=1.
- R7: Cycle bits 22:20 hold a divider exponent d. The channel counter advances once every 2^d clock cycles.
- R8: A write to a running channel's window or cycle register is visible on reads at once, but it reaches the output only after the counter wraps. A disabled channel picks up new values on every clock.
- R9: A disabled channel holds its counter at 0 and drives oe=0 and level=0. Once enabled, it starts its first cycle at count 0 with the current register values.
- R10: Channels run independently. Programming, enabling or disabling one channel does not change another channel's output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers and counters |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W-2 | Word address, byte address bits ADDR_W-1:2 |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| pwm_level | output | NCH | Output level per channel |
| pwm_oe | output | NCH | Output-enable per channel |

## Verification
A wrong counter or prescaler state shows up as a cycle of the wrong length or a misplaced phase edge on `pwm_level` or `pwm_oe` within one output cycle. For that reason the bench compares both outputs against its reference model on every clock, not only at selected points. A shadow copy taken at the wrong moment produces a change mid-cycle, one clock after the offending register write, instead of at the next wrap. Alias decode errors appear directly on `bus_rdata` in the read that follows the write. A channel that leaks into its neighbour breaks the neighbour's rise-to-rise spacing, which the bench measures while the other channel is being reprogrammed.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // counter and field geometry of the cycle register
   localparam int CNT_W       = 16;
   localparam int CODE_W      = 2;
   localparam int DIV_W       = 3;
   localparam int PER_USED_W  = CNT_W + 2 * CODE_W + DIV_W;
   localparam logic [31:0] PER_MASK = 32'((64'd1 << PER_USED_W) - 1);

   // access kind, decoded from byte address bits 3:2
   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_SET   = 2'd1,
      OP_CLEAR = 2'd2,
      OP_FLIP  = 2'd3
   } alias_op_e;

   // drive codes for a phase
   typedef enum logic [CODE_W-1:0] {
      DRV_OFF0 = 2'd0,
      DRV_OFF1 = 2'd1,
      DRV_LOW  = 2'd2,
      DRV_HIGH = 2'd3
   } drive_code_e;

   // used part of the cycle register, lsb first at the bottom
   typedef struct packed {
      logic [DIV_W-1:0]  div;
      logic [CODE_W-1:0] idle_code;
      logic [CODE_W-1:0] act_code;
      logic [CNT_W-1:0]  period;
   } cycle_cfg_t;

   // window register
   typedef struct packed {
      logic [CNT_W-1:0] stop;
      logic [CNT_W-1:0] start;
   } window_cfg_t;

   function automatic logic [31:0] apply_op(alias_op_e op, logic [31:0] cur,
                                            logic [31:0] wd);
      logic [31:0] res;
      unique case (op)
         OP_WRITE: res = wd;
         OP_SET:   res = cur | wd;
         OP_CLEAR: res = cur & ~wd;
         default:  res = cur ^ wd;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int ADDR_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:2]          addr,
   input  logic [31:0]                wdata,
   input  logic                       wr,
   output logic [31:0]                rdata,
   output logic [NCH-1:0]             en_q,
   output logic [NCH-1:0][31:0]       win_q,
   output logic [NCH-1:0][PER_USED_W-1:0] cyc_q
);

   localparam int IDX_W = ADDR_W - 4;
   localparam int LAST_IDX = 2 * NCH;

   initial begin : elab_chk
      if (IDX_W < 1 || LAST_IDX >= (1 << IDX_W))
         $error("pwm_bank_regs: ADDR_W %0d too small for %0d channels", ADDR_W, NCH);
   end

   alias_op_e        op;
   logic [IDX_W-1:0] idx;
   logic             hit_ctrl;
   logic [NCH-1:0]   hit_win;
   logic [NCH-1:0]   hit_cyc;

   assign op       = alias_op_e'(addr[3:2]);
   assign idx      = addr[ADDR_W-1:4];
   assign hit_ctrl = (idx == '0);

   // control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (wr && hit_ctrl)
         en_q <= NCH'(apply_op(op, 32'(en_q), wdata));
   end

   // per-channel register pair
   for (genvar c = 0; c < NCH; c++) begin : g_chreg
      logic [31:0] cyc_full;

      assign hit_win[c] = (idx == IDX_W'(2 * c + 1));
      assign hit_cyc[c] = (idx == IDX_W'(2 * c + 2));
      assign cyc_full   = 32'(cyc_q[c]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q[c] <= '0;
            cyc_q[c] <= '0;
         end else if (wr) begin
            if (hit_win[c])
               win_q[c] <= apply_op(op, win_q[c], wdata);
            if (hit_cyc[c])
               cyc_q[c] <= PER_USED_W'(apply_op(op, cyc_full, wdata) & PER_MASK);
         end
      end
   end

   // read mux: every alias returns the base value, holes read zero
   always_comb begin
      rdata = '0;
      if (hit_ctrl)
         rdata = 32'(en_q);
      for (int c = 0; c < NCH; c++) begin
         if (hit_win[c]) rdata = win_q[c];
         if (hit_cyc[c]) rdata = 32'(cyc_q[c]);
      end
   end

   AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_ctrl && op == OP_SET) |=> ((en_q & $past(en_q)) == $past(en_q))); // R2

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_ctrl && op == OP_CLEAR) |=> ((en_q & $past(wdata[NCH-1:0])) == '0)); // R2

endmodule

// File: rtl/pwm_bank_presc.sv
module pwm_bank_presc
   import pwm_bank_pkg::*;
#(
   parameter int EXP_W = DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [(EXP_W > 0 ? EXP_W : 1)-1:0] exp_sel,
   output logic             tick
);

   if (EXP_W == 0) begin : g_nodiv
      logic unused_sel;
      assign unused_sel = exp_sel[0];
      assign tick = run;
   end else begin : g_div
      localparam int PRE_W = (1 << EXP_W) - 1;

      logic [PRE_W-1:0] pre_q;
      logic [PRE_W-1:0] low_mask;

      // ones in the low exp_sel bits
      always_comb begin
         for (int i = 0; i < PRE_W; i++)
            low_mask[i] = (i < int'(exp_sel));
      end

      assign tick = run && ((pre_q & low_mask) == low_mask);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pre_q <= '0;
         else if (!run)
            pre_q <= '0;
         else
            pre_q <= pre_q + PRE_W'(1);
      end

      AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> (pre_q == '0)); // R7
   end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
   import pwm_bank_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [31:0]           win_live,
   input  logic [PER_USED_W-1:0] cyc_live,
   output logic                  level,
   output logic                  oe
);

   window_cfg_t      win_sh;
   cycle_cfg_t       cyc_sh;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;
   logic             wrap;
   logic             in_act;
   drive_code_e      code;

   pwm_bank_presc #(.EXP_W(DIV_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en),
      .exp_sel (cyc_sh.div),
      .tick    (tick)
   );

   assign wrap = tick && (cnt_q >= cyc_sh.period);

   // counter with shadow copies loaded at wrap or while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         win_sh <= '0;
         cyc_sh <= '0;
      end else if (!en) begin
         cnt_q  <= '0;
         win_sh <= window_cfg_t'(win_live);
         cyc_sh <= cycle_cfg_t'(cyc_live);
      end else if (wrap) begin
         cnt_q  <= '0;
         win_sh <= window_cfg_t'(win_live);
         cyc_sh <= cycle_cfg_t'(cyc_live);
      end else if (tick) begin
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   assign in_act = (cnt_q >= win_sh.start) && (cnt_q < win_sh.stop);
   assign code   = drive_code_e'(in_act ? cyc_sh.act_code : cyc_sh.idle_code);
   assign oe     = en && (code == DRV_LOW || code == DRV_HIGH);
   assign level  = en && (code == DRV_HIGH);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= cyc_sh.period); // R4

   AST_DIS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0)); // R9

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt_q != '0) |-> ($stable(win_sh) && $stable(cyc_sh))); // R8

   AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt_q != '0) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1))); // R4

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:2] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_wr,
   output logic [31:0]       bus_rdata,
   output logic [NCH-1:0]    pwm_level,
   output logic [NCH-1:0]    pwm_oe
);

   initial begin : elab_chk
      if (NCH < 1 || NCH > 32)
         $error("pwm_bank: NCH %0d outside 1..32", NCH);
      if (ADDR_W < 6)
         $error("pwm_bank: ADDR_W %0d below 6", ADDR_W);
   end

   logic [NCH-1:0]                 en_q;
   logic [NCH-1:0][31:0]           win_q;
   logic [NCH-1:0][PER_USED_W-1:0] cyc_q;

   pwm_bank_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .wr    (bus_wr),
      .rdata (bus_rdata),
      .en_q  (en_q),
      .win_q (win_q),
      .cyc_q (cyc_q)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pwm_bank_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (en_q[c]),
         .win_live (win_q[c]),
         .cyc_live (cyc_q[c]),
         .level    (pwm_level[c]),
         .oe       (pwm_oe[c])
      );
   end

endmodule

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;

   localparam int NCH    = 2;
   localparam int ADDR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:2] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_wr = 1'b0;
   logic [31:0]       bus_rdata;
   logic [NCH-1:0]    pwm_level;
   logic [NCH-1:0]    pwm_oe;

   always #2 clk = ~clk;

   pwm_bank #(.NCH(NCH), .ADDR_W(ADDR_W)) u_pwm_bank (
      .clk, .rst_n, .bus_addr, .bus_wdata, .bus_wr, .bus_rdata, .pwm_level, .pwm_oe
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;
   string cur_tag = "R1";

   // reference model state
   logic [31:0] m_ctrl;
   logic [31:0] m_win [NCH];
   logic [31:0] m_cyc [NCH];
   logic [31:0] s_win [NCH];
   logic [31:0] s_cyc [NCH];
   int unsigned m_cnt [NCH];
   int unsigned m_pre [NCH];

   task automatic check(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(logic [7:0] a);
      int idx = int'(a >> 4);
      if (idx == 0) return m_ctrl;
      if (idx <= 2 * NCH) begin
         if (idx % 2 == 1) return m_win[(idx - 1) / 2];
         return m_cyc[idx / 2 - 1];
      end
      return 32'h0;
   endfunction

   function automatic logic [31:0] op_apply(int kind, logic [31:0] cur, logic [31:0] d);
      case (kind)
         0: return d;
         1: return cur | d;
         2: return cur & ~d;
         default: return cur ^ d;
      endcase
   endfunction

   task automatic model_reset();
      m_ctrl = 0;
      for (int c = 0; c < NCH; c++) begin
         m_win[c] = 0; m_cyc[c] = 0; s_win[c] = 0; s_cyc[c] = 0;
         m_cnt[c] = 0; m_pre[c] = 0;
      end
   endtask

   // one rising edge of the reference
   task automatic model_step();
      logic [7:0] a;
      int         idx;
      int         kind;
      for (int c = 0; c < NCH; c++) begin
         if (!m_ctrl[c]) begin
            m_cnt[c] = 0; m_pre[c] = 0;
            s_win[c] = m_win[c]; s_cyc[c] = m_cyc[c];
         end else begin
            int unsigned d    = (s_cyc[c] >> 20) & 7;
            int unsigned mask = (1 << d) - 1;
            bit          tk   = ((m_pre[c] & mask) == mask);
            m_pre[c] = (m_pre[c] + 1) % 128;
            if (tk) begin
               if (m_cnt[c] >= (s_cyc[c] & 32'hFFFF)) begin
                  m_cnt[c] = 0;
                  s_win[c] = m_win[c]; s_cyc[c] = m_cyc[c];
               end else begin
                  m_cnt[c]++;
               end
            end
         end
      end
      if (bus_wr) begin
         a    = {bus_addr, 2'b00};
         idx  = int'(a >> 4);
         kind = int'(a[3:2]);
         if (idx == 0)
            m_ctrl = op_apply(kind, m_ctrl, bus_wdata) & ((32'd1 << NCH) - 1);
         else if (idx <= 2 * NCH) begin
            if (idx % 2 == 1)
               m_win[(idx - 1) / 2] = op_apply(kind, m_win[(idx - 1) / 2], bus_wdata);
            else
               m_cyc[idx / 2 - 1] = op_apply(kind, m_cyc[idx / 2 - 1], bus_wdata) & 32'h7FFFFF;
         end
      end
   endtask

   task automatic compare_outputs();
      for (int c = 0; c < NCH; c++) begin
         int unsigned st   = s_win[c] & 32'hFFFF;
         int unsigned sp   = s_win[c] >> 16;
         bit          act  = (m_cnt[c] >= st) && (m_cnt[c] < sp);
         int unsigned code = act ? ((s_cyc[c] >> 16) & 3) : ((s_cyc[c] >> 18) & 3);
         bit          e_oe = m_ctrl[c] && code >= 2;
         bit          e_lv = m_ctrl[c] && code == 3;
         check($sformatf("%s oe ch%0d", cur_tag, c), pwm_oe[c] == e_oe, 32'(pwm_oe[c]), 32'(e_oe));
         check($sformatf("%s level ch%0d", cur_tag, c), pwm_level[c] == e_lv,
               32'(pwm_level[c]), 32'(e_lv));
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_outputs();
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      bus_addr  = a[7:2];
      bus_wdata = d;
      bus_wr    = 1'b1;
      cycle();
      bus_wr    = 1'b0;
   endtask

   task automatic read_chk(string tag, logic [7:0] a, logic [31:0] exp);
      bus_addr = a[7:2];
      bus_wr   = 1'b0;
      #0.5;
      check({tag, " read exp"}, bus_rdata == exp, bus_rdata, exp);
      check({tag, " read model"}, bus_rdata == model_read(a), bus_rdata, model_read(a));
   endtask

   // clocks between two rising edges of a channel's level
   task automatic rise_gap(int c, output int gap);
      bit prev;
      int guard = 0;
      gap  = 0;
      prev = pwm_level[c];
      while (!(pwm_level[c] && !prev) && guard < 4000) begin
         prev = pwm_level[c]; cycle(); guard++;
      end
      prev = pwm_level[c];
      cycle(); gap = 1;
      while (!(pwm_level[c] && !prev) && guard < 4000) begin
         prev = pwm_level[c]; cycle(); gap++; guard++;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int g;
      int n;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cur_tag = "R1";
      compare_outputs();
      check("R1 oe after reset", pwm_oe == '0, 32'(pwm_oe), 0);
      read_chk("R1", 8'h00, 0);
      read_chk("R1", 8'h10, 0);
      read_chk("R1", 8'h20, 0);
      read_chk("R1", 8'h30, 0);
      read_chk("R1", 8'h40, 0);

      // R2 / R3: program channel 0 and read back through aliases
      cur_tag = "R3";
      bus_write(8'h20, 32'h000B_0009);
      bus_write(8'h10, 32'h0004_0001);
      read_chk("R3", 8'h20, 32'h000B_0009);
      read_chk("R2", 8'h24, 32'h000B_0009);
      read_chk("R2", 8'h28, 32'h000B_0009);
      read_chk("R2", 8'h2C, 32'h000B_0009);
      read_chk("R3", 8'h10, 32'h0004_0001);
      bus_write(8'h04, 32'h1);
      read_chk("R3", 8'h00, 32'h1);

      // R4 / R5: cycle of 10 clocks, active for counts 1..3
      cur_tag = "R5";
      run(25);
      rise_gap(0, g);
      check("R4 cycle length ch0", g == 10, 32'(g), 10);
      n = 0;
      for (int i = 0; i < 10; i++) begin
         cycle();
         if (pwm_level[0]) n++;
      end
      check("R5 active clocks per cycle ch0", n == 3, 32'(n), 3);

      // R7: channel 1 with cycle 3 and divider exponent 2
      cur_tag = "R7";
      bus_write(8'h40, 32'h002B_0003);
      bus_write(8'h30, 32'h0002_0000);
      bus_write(8'h04, 32'h2);
      read_chk("R7", 8'h00, 32'h3);
      rise_gap(1, g);
      check("R7 prescaled cycle ch1", g == 16, 32'(g), 16);
      cur_tag = "R10";
      rise_gap(0, g);
      check("R10 ch0 unaffected by ch1", g == 10, 32'(g), 10);

      // R8: lengthen ch0 mid-cycle, takes effect after wrap
      cur_tag = "R8";
      run(4);
      bus_write(8'h20, 32'h000B_0013);
      read_chk("R8", 8'h20, 32'h000B_0013);
      run(30);
      rise_gap(0, g);
      check("R8 new cycle length ch0", g == 20, 32'(g), 20);

      // R2: set, clear and flip aliases on the window register
      cur_tag = "R2";
      bus_write(8'h14, 32'h0001_0000);
      read_chk("R2 set", 8'h10, 32'h0005_0001);
      bus_write(8'h18, 32'h0000_0001);
      read_chk("R2 clear", 8'h10, 32'h0005_0000);
      bus_write(8'h1C, 32'h0000_0003);
      read_chk("R2 flip", 8'h10, 32'h0005_0003);

      // R6: inactive code 1 floats the pin outside counts 3..4
      cur_tag = "R6";
      bus_write(8'h2C, 32'h000C_0000);
      read_chk("R6", 8'h20, 32'h0007_0013);
      run(45);
      n = 0;
      for (int i = 0; i < 20; i++) begin
         cycle();
         if (pwm_oe[0]) n++;
      end
      check("R6 oe clocks per cycle ch0", n == 2, 32'(n), 2);

      // R9: disable then re-enable channel 0, disable channel 1
      cur_tag = "R9";
      bus_write(8'h08, 32'h1);
      for (int i = 0; i < 5; i++) begin
         check("R9 disabled oe ch0", pwm_oe[0] == 1'b0, 32'(pwm_oe[0]), 0);
         check("R9 disabled level ch0", pwm_level[0] == 1'b0, 32'(pwm_level[0]), 0);
         cycle();
      end
      bus_write(8'h0C, 32'h3);
      read_chk("R9", 8'h00, 32'h1);
      check("R9 ch1 off", pwm_oe[1] == 1'b0, 32'(pwm_oe[1]), 0);
      n = 0;
      while (!pwm_oe[0] && n < 100) begin
         cycle(); n++;
      end
      check("R9 restart from count 0", n == 3, 32'(n), 3);

      // R3: holes, reserved bits
      cur_tag = "R3";
      bus_write(8'h80, 32'hFFFF_FFFF);
      read_chk("R3 hole", 8'h80, 32'h0);
      read_chk("R3 hole no effect", 8'h00, 32'h1);
      read_chk("R3 hole no effect", 8'h40, 32'h002B_0003);
      bus_write(8'h40, 32'hFFFF_FFFF);
      read_chk("R3 cycle reserved", 8'h40, 32'h007F_FFFF);
      bus_write(8'h00, 32'hFFFF_FFFF);
      read_chk("R3 control reserved", 8'h00, 32'h3);
      run(20);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule